// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives one active-low system reset from three causes. The first is the supply-good input from an external comparator. The second is the power-up and brownout hold time that follows recovery of that supply. The third is a watchdog that monitors a strobe line which doubles as a chip-select. Every interval is counted in milliseconds. A prescaler turns the free-running clock into millisecond ticks, and parameters set both the ticks per millisecond and the length of each period. A testbench can therefore shrink all timing to a few clock cycles.

The watchdog is kicked only by a falling edge of the strobe, taken after a two-flop synchronizer. A 2-bit select picks one of three timeouts or turns the watchdog off. When the watchdog expires, the reset is held for a pulse whose length depends on the select in force at that moment. A one-cycle flag marks a reset that the watchdog caused, so software can tell it apart from a supply event. The analog comparator, threshold trimming and open-drain pad are outside this block.

Top module: `rsup_supervisor`

## Requirements
- R1: While `rst` is high, and while `vcc_ok` is low after `rst`, `reset_n` is 0 and `wdt_fire` is 0.
- R2: After `vcc_ok` becomes continuously high, `reset_n` stays 0 for HOLD_MS*TICKS_PER_MS cycles, plus three cycles of synchronizer and state latency, and then goes to 1.
- R3: A low level on `vcc_ok` forces `reset_n` to 0 in the same cycle, without waiting for a clock edge. When the supply returns, the full hold period of R2 starts again, even if a hold period was already under way.
- R4: Only a falling edge of the synchronized `wd_strobe` restarts the watchdog. A rising edge has no effect, and regular kicks that come sooner than the timeout keep `reset_n` at 1.
- R5: If `wd_strobe` stays steady, either high or low, for longer than the selected timeout, the watchdog asserts reset.
- R6: The `wd_sel` encoding is 2'b00 for WDT_LONG_MS (1400), 2'b01 for WDT_MID_MS (600), 2'b10 for WDT_SHORT_MS (400) and 2'b11 for watchdog off.
- R7: A watchdog reset lasts PULSE_SHORT_MS (200) when the select was 2'b00 or 2'b01, and PULSE_LONG_MS (400) when it was 2'b10.
- R8: `wdt_fire` is high for exactly one cycle, in the same cycle in which `reset_n` falls because of a watchdog expiry. It never pulses because of a supply event.
- R9: The watchdog count is held at zero while any reset is active, and it starts fresh when reset is released. Strobe edges during a reset therefore have no effect, and a timeout is measured from the release.
- R10: A change of `wd_sel` while the watchdog is running restarts the timeout count.
- R11: With `wd_sel` = 2'b11 the watchdog never asserts reset and never pulses `wdt_fire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset of the supervisor logic |
| vcc_ok | input | 1 | Supply-good level from the external comparator |
| wd_strobe | input | 1 | Shared chip-select / watchdog kick line, asynchronous |
| wd_sel | input | 2 | Watchdog timeout select (R6 encoding) |
| reset_n | output | 1 | Active-low system reset |
| wdt_fire | output | 1 | One-cycle marker of a watchdog-caused reset |

## Verification
The bound checker checks four rules on every cycle. The reset follows a supply drop in the same cycle. A release never comes before the hold count measured from the last supply rise. The fire flag lasts one cycle and coincides with an active reset. No fire occurs while the watchdog is disabled. The exact timeout and pulse lengths for each select code cannot be seen by the checker, and neither can the absence of any effect from rising strobe edges, the restart on a select change, or the restart of the hold period after a brownout in mid-hold. The bench scenarios, run with shrunk timing parameters, measure those intervals in cycles.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        SUP_BROWN = 2'd0,
        SUP_HOLD  = 2'd1,
        SUP_RUN   = 2'd2,
        SUP_WDRST = 2'd3
    } sup_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

    typedef struct packed {
        logic       enabled;
        logic       long_pulse;
        logic [1:0] code;
    } wdt_cfg_t;

    function automatic wdt_cfg_t decode_sel(input logic [1:0] s);
        wdt_cfg_t c;
        c.code       = s;
        c.enabled    = (s != SEL_OFF);
        c.long_pulse = (s == SEL_SHORT);
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {(STAGES+1){INIT}};
        end else begin
            chain <= {chain[STAGES-1:0], d};
        end
    end

    assign q    = chain[STAGES-1];
    assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rsup_interval.sv
module rsup_interval #(
    parameter int TICKS_PER_MS = 50000,
    parameter int MSW          = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic [MSW-1:0] limit,
    output logic           done
);
    localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_MS - 1);

    logic [PW-1:0]  pre_q;
    logic [MSW-1:0] ms_q;
    logic           tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            ms_q  <= ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign done = tick && (ms_q == (limit - 1'b1));
endmodule

// File: rtl/rsup_supervisor.sv
module rsup_supervisor
    import rsup_pkg::*;
#(
    parameter int TICKS_PER_MS   = 50000,
    parameter int HOLD_MS        = 800,
    parameter int WDT_LONG_MS    = 1400,
    parameter int WDT_MID_MS     = 600,
    parameter int WDT_SHORT_MS   = 400,
    parameter int PULSE_SHORT_MS = 200,
    parameter int PULSE_LONG_MS  = 400,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_ok,
    input  logic       wd_strobe,
    input  logic [1:0] wd_sel,
    output logic       reset_n,
    output logic       wdt_fire
);
    localparam int MAX_MS = max2(max2(max2(HOLD_MS, WDT_LONG_MS), max2(WDT_MID_MS, WDT_SHORT_MS)),
                                 max2(PULSE_SHORT_MS, PULSE_LONG_MS));
    localparam int MSW = $clog2(MAX_MS + 1);

    logic           vcc_s;
    logic           vcc_fall_unused;
    logic           strobe_s;
    logic           kick;
    logic           restart;
    logic           done;
    logic [MSW-1:0] limit;

    sup_state_e     state_q, state_nx;
    logic [1:0]     sel_q;
    logic           pulse_long_q, pulse_long_nx;
    logic           fire_q, fire_nx;
    logic           run_q;
    wdt_cfg_t       cfg;
    logic           sel_chg;

    rsup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) vcc_sync_i (
        .clk(clk), .rst(rst), .d(vcc_ok), .q(vcc_s), .fall(vcc_fall_unused)
    );

    rsup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) strobe_sync_i (
        .clk(clk), .rst(rst), .d(wd_strobe), .q(strobe_s), .fall(kick)
    );

    rsup_interval #(.TICKS_PER_MS(TICKS_PER_MS), .MSW(MSW)) timer_i (
        .clk(clk), .rst(rst), .restart(restart), .limit(limit), .done(done)
    );

    assign cfg     = decode_sel(wd_sel);
    assign sel_chg = (wd_sel != sel_q);

    always_comb begin
        unique case (state_q)
            SUP_RUN: begin
                unique case (wd_sel)
                    SEL_LONG:  limit = MSW'(WDT_LONG_MS);
                    SEL_MID:   limit = MSW'(WDT_MID_MS);
                    default:   limit = MSW'(WDT_SHORT_MS);
                endcase
            end
            SUP_WDRST: limit = pulse_long_q ? MSW'(PULSE_LONG_MS) : MSW'(PULSE_SHORT_MS);
            default:   limit = MSW'(HOLD_MS);
        endcase
    end

    always_comb begin
        state_nx      = state_q;
        restart       = 1'b0;
        fire_nx       = 1'b0;
        pulse_long_nx = pulse_long_q;
        unique case (state_q)
            SUP_BROWN: begin
                restart = 1'b1;
                if (vcc_s) state_nx = SUP_HOLD;
            end
            SUP_HOLD: begin
                if (done) begin
                    state_nx = SUP_RUN;
                    restart  = 1'b1;
                end
            end
            SUP_RUN: begin
                if (!cfg.enabled || sel_chg || kick) begin
                    restart = 1'b1;
                end else if (done) begin
                    state_nx      = SUP_WDRST;
                    restart       = 1'b1;
                    fire_nx       = 1'b1;
                    pulse_long_nx = cfg.long_pulse;
                end
            end
            SUP_WDRST: begin
                if (done) begin
                    state_nx = SUP_RUN;
                    restart  = 1'b1;
                end
            end
            default: begin
                state_nx = SUP_BROWN;
                restart  = 1'b1;
            end
        endcase
        if (!vcc_s) begin
            state_nx = SUP_BROWN;
            restart  = 1'b1;
            fire_nx  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SUP_BROWN;
            sel_q        <= SEL_LONG;
            pulse_long_q <= 1'b0;
            fire_q       <= 1'b0;
            run_q        <= 1'b0;
        end else begin
            state_q      <= state_nx;
            sel_q        <= wd_sel;
            pulse_long_q <= pulse_long_nx;
            fire_q       <= fire_nx;
            run_q        <= (state_nx == SUP_RUN);
        end
    end

    assign reset_n  = run_q & vcc_ok;
    assign wdt_fire = fire_q;
endmodule

// File: rtl/rsup_supervisor_chk.sv
module rsup_supervisor_chk #(
    parameter int TICKS_PER_MS = 50000,
    parameter int HOLD_MS      = 800
) (
    input logic       clk,
    input logic       rst,
    input logic       vcc_ok,
    input logic [1:0] wd_sel,
    input logic       reset_n,
    input logic       wdt_fire
);
    localparam int HOLD_CYC = TICKS_PER_MS * HOLD_MS;
    localparam int CW       = $clog2(HOLD_CYC + 2);

    logic [CW-1:0] up_cnt;

    always_ff @(posedge clk) begin
        if (rst || !vcc_ok) up_cnt <= '0;
        else if (up_cnt < CW'(HOLD_CYC)) up_cnt <= up_cnt + 1'b1;
    end

    p_drop_forces_reset_r3: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok |-> !reset_n);

    p_hold_respected_r2: assert property (@(posedge clk) disable iff (rst)
        reset_n |-> (up_cnt >= CW'(HOLD_CYC)));

    p_fire_single_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_fire |=> !wdt_fire);

    p_fire_in_reset_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_fire |-> !reset_n);

    p_off_no_fire_r11: assert property (@(posedge clk) disable iff (rst)
        wdt_fire |-> ($past(wd_sel) != 2'b11));
endmodule

bind rsup_supervisor rsup_supervisor_chk #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .HOLD_MS(HOLD_MS)
) chk_i (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .wd_sel(wd_sel),
    .reset_n(reset_n), .wdt_fire(wdt_fire)
);

// File: tb/rsup_supervisor_tb_top.sv
`timescale 1ns/1ps
module rsup_supervisor_tb_top;
    localparam int TPM   = 4;
    localparam int HOLD  = 8;
    localparam int T_L   = 14;
    localparam int T_M   = 6;
    localparam int T_S   = 4;
    localparam int P_S   = 2;
    localparam int P_L   = 4;
    localparam int HOLD_CYC = HOLD * TPM + 3;

    typedef struct packed {
        logic [1:0] sel;
        int         to_cyc;
        int         pl_cyc;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{2'b00, T_L * TPM, P_S * TPM},
        '{2'b01, T_M * TPM, P_S * TPM},
        '{2'b10, T_S * TPM, P_L * TPM}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       vcc_ok;
    logic       wd_strobe;
    logic [1:0] wd_sel;
    logic       reset_n;
    logic       wdt_fire;

    int checks = 0;
    int failures = 0;
    int fire_cnt = 0;
    int low_seen = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rsup_supervisor #(
        .TICKS_PER_MS(TPM), .HOLD_MS(HOLD), .WDT_LONG_MS(T_L), .WDT_MID_MS(T_M),
        .WDT_SHORT_MS(T_S), .PULSE_SHORT_MS(P_S), .PULSE_LONG_MS(P_L), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .wd_strobe(wd_strobe),
        .wd_sel(wd_sel), .reset_n(reset_n), .wdt_fire(wdt_fire)
    );

    always @(negedge clk) begin
        cyc++;
        if (wdt_fire) fire_cnt++;
        if (!reset_n) low_seen++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp);
        check((act >= exp - 1) && (act <= exp + 1), req, act, exp);
    endtask

    task automatic count_until(input logic lvl, input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(negedge clk);
            n++;
            if (reset_n === lvl) break;
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        int f0;
        int l0;
        rst = 1'b1; vcc_ok = 1'b0; wd_strobe = 1'b1; wd_sel = 2'b00;
        wait_cyc(5);
        check(reset_n == 1'b0, "R1 reset_n in rst", int'(reset_n), 0);
        check(wdt_fire == 1'b0, "R1 wdt_fire in rst", int'(wdt_fire), 0);
        rst = 1'b0;
        wait_cyc(6);
        check(reset_n == 1'b0, "R1 reset_n supply low", int'(reset_n), 0);

        // Table walk: hold (R2), timeout (R5 R6 R9), fire (R8), pulse (R7)
        for (int v = 0; v < 3; v++) begin
            wd_sel = VECS[v].sel;
            vcc_ok = 1'b0;
            wait_cyc(4);
            vcc_ok = 1'b1;
            count_until(1'b1, 500, n);
            check_near("R2 hold length", n, HOLD_CYC);
            count_until(1'b0, 500, n);
            check_near("R6 R9 timeout from release", n, VECS[v].to_cyc);
            check(wdt_fire == 1'b1, "R8 fire with reset edge", int'(wdt_fire), 1);
            @(negedge clk);
            check(wdt_fire == 1'b0, "R8 fire one cycle", int'(wdt_fire), 0);
            count_until(1'b1, 500, n);
            check_near("R7 pulse length", n, VECS[v].pl_cyc - 1);
        end

        // R4: regular kicks keep reset released (sel 10, 16 cycles)
        l0 = low_seen;
        for (int k = 0; k < 12; k++) begin
            wait_cyc(8);
            wd_strobe = 1'b0;
            @(negedge clk);
            wd_strobe = 1'b1;
        end
        check(low_seen == l0, "R4 kicks keep alive", low_seen - l0, 0);

        // R5: strobe held low
        wd_strobe = 1'b0;
        count_until(1'b0, 500, n);
        check_near("R5 steady low timeout", n, T_S * TPM + 3);
        // R9: strobe edges during pulse ignored; R4: rising edge not a kick
        count_until(1'b1, 500, n);
        wd_strobe = 1'b1;
        wait_cyc(8);
        count_until(1'b0, 500, n);
        check_near("R4 rising edge ignored", n, T_S * TPM - 8);
        count_until(1'b1, 500, n);

        // R10: select change restarts count
        wait_cyc(12);
        wd_sel = 2'b01;
        count_until(1'b0, 500, n);
        check_near("R10 select change restart", n, T_M * TPM);
        count_until(1'b1, 500, n);
        check_near("R7 short pulse after change", n, P_S * TPM);

        // R11: disabled watchdog
        wd_sel = 2'b11;
        f0 = fire_cnt;
        l0 = low_seen;
        wait_cyc(300);
        check(low_seen == l0, "R11 no reset when off", low_seen - l0, 0);
        check(fire_cnt == f0, "R11 no fire when off", fire_cnt - f0, 0);

        // R3: immediate reset on drop, hold restarts after brownout in hold
        f0 = fire_cnt;
        vcc_ok = 1'b0;
        #1;
        check(reset_n == 1'b0, "R3 immediate drop", int'(reset_n), 0);
        wait_cyc(4);
        vcc_ok = 1'b1;
        wait_cyc(15);
        vcc_ok = 1'b0;
        wait_cyc(3);
        vcc_ok = 1'b1;
        count_until(1'b1, 500, n);
        check_near("R3 hold restarted", n, HOLD_CYC);
        check(fire_cnt == f0, "R8 no fire on supply event", fire_cnt - f0, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule